// File: doc/BRIEF.md
# Self-Clocked Conversion Result Serializer

This block is the output side of a converter that supplies its own serial clock. A conversion-done strobe hands it a 32-bit result word. The block then drives the serial clock and serial data pin levels, so an external receiver can shift the result in. It does this without any clock from the receiver.

Between frames, both lines sit high. This level tells the receiver that a conversion is in progress. When a result is ready, both lines drop low, which marks the end of conversion. The block then waits a short sleep gap. After the gap it produces 32 clock cycles, each lasting `SCK_DIV` system clocks, and moves the data line only on falling edges. Once the last rising edge is out, both lines return high and a one-cycle conversion-start strobe is issued.

Clock-mode selection happens once, at the end of a power-on window that runs while the supply-good input is high. If the clock pin reads high when the window closes, the block runs in self-clocked mode. Otherwise it reports the receiver-clocked mode and leaves both lines idle high.

Top module: `adc_frame_serializer`

## Requirements
- R1: After reset, `mode_ready` is 0 and both lines are high. `mode_ready` rises once `supply_ok` has been high for `POR_CYCLES` consecutive clocks. A low cycle on `supply_ok` before that restarts the count.
- R2: When `mode_ready` rises, `mode_internal` takes the value of `sck_pin_in` and then holds it. With `mode_internal` = 0, both lines stay high, `conv_done` has no effect and `conv_start` stays 0.
- R3: While no frame is being sent (the busy state), `sck_out` and `sdo_out` are both 1.
- R4: The cycle after an accepted `conv_done`, both lines are 0. They stay 0 for ceil(`SCK_DIV`/2) system clocks before the first rising edge of `sck_out`.
- R5: A frame has exactly 32 rising edges of `sck_out`. Each high phase lasts floor(`SCK_DIV`/2) clocks and each low phase lasts `SCK_DIV` minus that.
- R6: The bits read at successive rising edges are the latched word, MSB first, with bit 31 forced to 0. The first bit therefore reads as end-of-conversion = 0.
- R7: Inside a frame, `sdo_out` changes only in the cycle in which `sck_out` falls.
- R8: The cycle after the 32nd rising edge, `sdo_out` is 1, `sck_out` is still 1, and `conv_start` is 1 for exactly one clock.
- R9: A `conv_done` that arrives while a frame is in progress is ignored. The data already latched is sent unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication that drives the power-on window |
| sck_pin_in | input | 1 | Level read on the clock pin at the end of the power-on window |
| conv_done | input | 1 | One-cycle strobe: a result word is ready |
| conv_word | input | 32 | Result word, latched with `conv_done` |
| sck_out | output | 1 | Serial clock pin level |
| sdo_out | output | 1 | Serial data pin level |
| conv_start | output | 1 | One-cycle strobe: a new conversion begins |
| mode_ready | output | 1 | Power-on window finished, mode decided |
| mode_internal | output | 1 | 1 = self-clocked mode, 0 = receiver-clocked mode |

## Verification
The hardest case to reach is a second result strobe that lands in the middle of a frame while the data input carries a different word. The bench raises `conv_done` with the inverted word exactly in the cycle of the eleventh falling edge. It then checks that every bit received afterwards still matches the original word, and that the lines stay high after the frame. A supply-good dropout partway through the power-on window is also staged, to prove that the count restarts and does not resume.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

  typedef enum logic [2:0] {
    ST_POR,
    ST_EXT,
    ST_BUSY,
    ST_SLEEP,
    ST_HI,
    ST_LO
  } ser_state_e;

  // high phase of one serial clock period, in system clocks
  function automatic int high_len(input int div);
    return div / 2;
  endfunction

  // low phase: whatever is left of the period
  function automatic int low_len(input int div);
    return div - (div / 2);
  endfunction

  // sleep gap between completion and first rising edge, rounded up
  function automatic int sleep_len(input int div);
    return (div + 1) / 2;
  endfunction

endpackage

// File: rtl/por_mode_select.sv
module por_mode_select #(
  parameter int POR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sck_pin_in,
  output logic por_done,
  output logic mode_internal
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          por_end_evt;

  assign por_end_evt = supply_ok && !por_done && (cnt == CW'(POR_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      por_done      <= 1'b0;
      mode_internal <= 1'b0;
    end else if (!por_done) begin
      if (!supply_ok) begin
        cnt <= '0;
      end else if (por_end_evt) begin
        por_done      <= 1'b1;
        mode_internal <= sck_pin_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_POR_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_done) |-> $past(supply_ok)); // R1
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (por_done && $past(por_done)) |-> $stable(mode_internal)); // R2

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift,
  output logic              msb
);
  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
    end else if (load) begin
      sreg           <= load_word;
      sreg[DATA_W-1] <= 1'b0;   // leading bit doubles as end-of-conversion flag
    end else if (shift) begin
      sreg <= {sreg[DATA_W-2:0], 1'b1};
    end
  end

  assign msb = sreg[DATA_W-1];

  AST_LEAD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !msb); // R6

endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer #(
  parameter int DATA_W     = 32,
  parameter int SCK_DIV    = 8,
  parameter int POR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              sck_pin_in,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_word,
  output logic              sck_out,
  output logic              sdo_out,
  output logic              conv_start,
  output logic              mode_ready,
  output logic              mode_internal
);
  import adcser_pkg::*;

  localparam int HI_T    = high_len(SCK_DIV);
  localparam int LO_T    = low_len(SCK_DIV);
  localparam int SLEEP_T = sleep_len(SCK_DIV);
  localparam int CNT_W   = $clog2(SCK_DIV + 1);
  localparam int EDGE_W  = $clog2(DATA_W + 1);

  ser_state_e        state;
  logic [CNT_W-1:0]  ph;
  logic [EDGE_W-1:0] edges;
  logic              shift_msb;

  // named internal events
  logic in_frame;
  logic frame_load_evt;
  logic bit_fall_evt;
  logic frame_end_evt;
  logic last_edge;

  assign in_frame       = (state == ST_SLEEP) || (state == ST_HI) || (state == ST_LO);
  assign last_edge      = (edges == EDGE_W'(DATA_W));
  assign frame_load_evt = (state == ST_BUSY) && conv_done;
  assign bit_fall_evt   = (state == ST_HI) && !last_edge && (ph == CNT_W'(HI_T - 1));
  assign frame_end_evt  = (state == ST_HI) && last_edge;

  por_mode_select #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .sck_pin_in   (sck_pin_in),
    .por_done     (mode_ready),
    .mode_internal(mode_internal)
  );

  frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_load_evt),
    .load_word(conv_word),
    .shift    (bit_fall_evt),
    .msb      (shift_msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_POR;
      ph         <= '0;
      edges      <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        ST_POR: begin
          if (mode_ready) state <= mode_internal ? ST_BUSY : ST_EXT;
        end
        ST_EXT: begin
          state <= ST_EXT;
        end
        ST_BUSY: begin
          if (frame_load_evt) begin
            state <= ST_SLEEP;
            ph    <= '0;
          end
        end
        ST_SLEEP: begin
          if (ph == CNT_W'(SLEEP_T - 1)) begin
            state <= ST_HI;
            ph    <= '0;
            edges <= EDGE_W'(1);
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_HI: begin
          if (frame_end_evt) begin
            state      <= ST_BUSY;
            conv_start <= 1'b1;
            edges      <= '0;
            ph         <= '0;
          end else if (bit_fall_evt) begin
            state <= ST_LO;
            ph    <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_LO: begin
          if (ph == CNT_W'(LO_T - 1)) begin
            state <= ST_HI;
            ph    <= '0;
            edges <= edges + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= ST_POR;
      endcase
    end
  end

  assign sck_out = !((state == ST_SLEEP) || (state == ST_LO));
  assign sdo_out = in_frame ? shift_msb : 1'b1;

  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= EDGE_W'(DATA_W)); // R5
  AST_SLEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> (!sck_out && !sdo_out)); // R4
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame) && (sdo_out != $past(sdo_out))) |-> $fell(sck_out)); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (sck_out && sdo_out && $past(sck_out)) ##1 !conv_start); // R8
  AST_EXT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ready && !mode_internal) |-> (sck_out && sdo_out && !conv_start)); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && conv_done) |=> (in_frame || conv_start)); // R9

endmodule

// File: tb/sim_adc_frame_serializer.sv
module sim_adc_frame_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 32;
  localparam int DIV        = 5;
  localparam int PORN       = 20;
  localparam int EXP_HI     = DIV / 2;
  localparam int EXP_LO     = DIV - DIV / 2;
  localparam int EXP_SLEEP  = (DIV + 1) / 2;
  localparam int NVEC       = 6;

  localparam logic [DW-1:0] VEC_IN [NVEC] = '{
    32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A,
    32'h8000_0001, 32'h1234_5678, 32'hDEAD_BEEF};
  localparam logic [DW-1:0] VEC_EXP [NVEC] = '{
    32'h7FFF_FFFF, 32'h0000_0000, 32'h25A5_5A5A,
    32'h0000_0001, 32'h1234_5678, 32'h5EAD_BEEF};

  logic clk = 1'b0;
  logic rst_n, supply_ok, sck_pin_in, conv_done;
  logic [DW-1:0] conv_word;
  logic sck_out, sdo_out, conv_start, mode_ready, mode_internal;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_frame_serializer #(.DATA_W(DW), .SCK_DIV(DIV), .POR_CYCLES(PORN)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sck_pin_in(sck_pin_in),
    .conv_done(conv_done), .conv_word(conv_word), .sck_out(sck_out),
    .sdo_out(sdo_out), .conv_start(conv_start), .mode_ready(mode_ready),
    .mode_internal(mode_internal));

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [DW-1:0] w, input logic [DW-1:0] exp_w, input logic stray);
    logic [DW-1:0] got;
    int hi, lo;
    logic bit_val, timing_bad, sdo_bad;
    got = '0; timing_bad = 1'b0; sdo_bad = 1'b0;
    @(negedge clk); conv_done = 1'b1; conv_word = w;
    @(negedge clk); conv_done = 1'b0;
    chk(!sck_out && !sdo_out, "R4 both low after done", {sck_out, sdo_out}, 0);
    lo = 0;
    while (sck_out == 1'b0) begin lo++; @(negedge clk); end
    chk(lo == EXP_SLEEP, "R4 sleep length", lo, EXP_SLEEP);
    for (int b = 0; b < DW; b++) begin
      got = {got[DW-2:0], sdo_out};
      if (b == DW - 1) break;
      bit_val = sdo_out; hi = 0;
      while (sck_out == 1'b1) begin
        if (sdo_out != bit_val) sdo_bad = 1'b1;
        hi++; @(negedge clk); conv_done = 1'b0;
      end
      if (hi != EXP_HI) timing_bad = 1'b1;
      if (stray && b == 10) begin conv_done = 1'b1; conv_word = ~w; end
      bit_val = sdo_out; lo = 0;
      while (sck_out == 1'b0) begin
        if (sdo_out != bit_val) sdo_bad = 1'b1;
        lo++; @(negedge clk); conv_done = 1'b0;
      end
      if (lo != EXP_LO) timing_bad = 1'b1;
      if (sdo_out != bit_val) sdo_bad = 1'b1;
    end
    chk(!timing_bad, "R5 phase lengths", timing_bad, 0);
    chk(!sdo_bad, "R7 sdo moves only on fall", sdo_bad, 0);
    chk(got == exp_w, stray ? "R9 stray done leaves data" : "R6 received word", got, exp_w);
    chk(!conv_start, "R8 no strobe at last rise", conv_start, 0);
    @(negedge clk);
    chk(sck_out && sdo_out && conv_start, "R8 lines high and strobe", {sck_out, sdo_out, conv_start}, 3'b111);
    @(negedge clk);
    chk(sck_out && sdo_out && !conv_start, "R3 busy high, strobe one cycle", {sck_out, sdo_out, conv_start}, 3'b110);
    if (stray) begin
      repeat (DIV * 2) @(negedge clk);
      chk(sck_out && sdo_out, "R9 no second frame", {sck_out, sdo_out}, 2'b11);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic saw;
    rst_n = 1'b0; supply_ok = 1'b0; sck_pin_in = 1'b0; conv_done = 1'b0; conv_word = '0;
    repeat (3) @(negedge clk);
    chk(!mode_ready && sck_out && sdo_out, "R1 reset state", {mode_ready, sck_out, sdo_out}, 3'b011);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!mode_ready, "R1 no ready without supply", mode_ready, 0);
    supply_ok = 1'b1;
    repeat (5) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!mode_ready);
    chk(n == PORN, "R1 window restarts after dropout", n, PORN);
    chk(!mode_internal, "R2 pin low selects external", mode_internal, 0);
    repeat (3) @(negedge clk);
    conv_done = 1'b1; conv_word = 32'h1234_5678;
    @(negedge clk); conv_done = 1'b0;
    saw = 1'b0;
    repeat (40) begin
      if (!sck_out || !sdo_out || conv_start) saw = 1'b1;
      @(negedge clk);
    end
    chk(!saw, "R2 external mode stays idle", saw, 0);

    rst_n = 1'b0; sck_pin_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!mode_ready);
    chk(n == PORN, "R1 window length", n, PORN);
    chk(mode_internal, "R2 pin high selects internal", mode_internal, 1);
    sck_pin_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(sck_out && sdo_out && mode_internal, "R3 busy lines high, R2 mode held", {sck_out, sdo_out, mode_internal}, 3'b111);

    for (int i = 0; i < NVEC; i++) run_frame(VEC_IN[i], VEC_EXP[i], i == 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule